// File: doc/BRIEF.md
# Counting and Tracking Converter Controller

This block is the digital side of a counting-type analog-to-digital converter. It drives a code onto an external DAC and reads back one comparator bit that says whether the analog input lies above the DAC level. Two modes are offered. In single-shot mode a start request clears the code, which then climbs one step at a time until the comparator stops reporting the input above the DAC level. That code is the result, and a status flag goes back to its done level. In tracking mode the code climbs or falls one step at a time and follows the input with no start needed.

The comparator is asynchronous to the block, so it passes through a synchronizer chain of `SYNC_STAGES` flops. The code changes at most once per step period of `SYNC_STAGES + 1` clocks, so every decision sees the comparator's answer for the code that is on the DAC at that moment. A hold input freezes the whole block, which then acts as a digital sample-and-hold with no time limit. In tracking mode two more inputs can block upward or downward steps. The code then keeps the lowest or the highest level the input reached.

Top module: `trk_conv`

## Requirements
- R1: While reset is high and after it is released, `dac_code` and `result` are 0 and `eoc` is 1.
- R2: A `start` pulse in single-shot mode (`mode_track`=0), with `eoc`=1 and `hold`=0, sets `dac_code` to 0 and `eoc` to 0 on that same clock edge.
- R3: During a conversion the code goes up by exactly one every 3 clocks (default `SYNC_STAGES`=2) while `cmp_above`=1. For an input level v, `eoc` returns to 1 and `result` equals v exactly 3·(v+1) clock edges after the accepting edge, so the conversion time grows with the input.
- R4: If `cmp_above` stays 1, a conversion stops at the all-ones code (255) after 768 edges and never wraps to 0.
- R5: A `start` pulse while `eoc`=0 is ignored. This includes a pulse on the very edge where the conversion ends. The result and the timing are unchanged and no new conversion begins.
- R6: In tracking mode (`mode_track`=1, `eoc`=1) the code goes up one step when `cmp_above`=1 and down one step when it is 0, once per step period, and `result` follows the code. For a steady input v the code settles on v-1 or v.
- R7: While `hold`=1, `dac_code`, `result` and `eoc` do not change and `start` is ignored. In single-shot mode each held clock lengthens the conversion by one clock.
- R8: In tracking mode with `no_up`=1 the code never rises. It settles one below the lowest input seen.
- R9: In tracking mode with `no_down`=1 the code never falls. It settles on the highest input seen.
- R10: In tracking mode the code saturates at 0 and at 255 and does not wrap.
- R11: A `start` pulse in tracking mode is ignored: `eoc` stays 1 and the code is not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_track | input | 1 | 0 = single-shot conversion, 1 = continuous tracking |
| start | input | 1 | Single-shot conversion request |
| hold | input | 1 | Freeze code, result and status |
| no_up | input | 1 | Tracking: block upward steps (minimum capture) |
| no_down | input | 1 | Tracking: block downward steps (maximum capture) |
| cmp_above | input | 1 | Asynchronous comparator: 1 when the input is above the DAC level |
| dac_code | output | CODE_W | Code driven onto the external DAC |
| result | output | CODE_W | Last conversion result, or the tracked code |
| eoc | output | 1 | 0 while a conversion runs, 1 when done or idle |

## Verification
A conversion that ends and a new start request can land on the same clock edge. The bench knows from the 3·(v+1) rule the exact edge on which `eoc` will rise, and drives `start` so that it is sampled on that edge. The check is that `eoc` stays 1, the result stays v and the code is not cleared in the cycles that follow. The same method is used for a hold that overlaps a running conversion: the expected completion edge moves back by exactly the number of held edges, and the scoreboard compares the result and the arrival cycle.

// File: rtl/trk_pkg.sv
package trk_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CONV = 1'b1
    } conv_state_e;

    typedef enum logic [1:0] {
        MV_NONE = 2'd0,
        MV_UP   = 2'd1,
        MV_DOWN = 2'd2
    } move_e;

    typedef struct packed {
        logic track;
        logic freeze;
        logic up_off;
        logic down_off;
    } trk_ctl_t;

    typedef struct packed {
        move_e move;
        logic  finish;
    } trk_dec_t;

    // One clock per synchronizer stage plus the clock that applies the step
    function automatic int pace_clks(input int sync_stages);
        return sync_stages + 1;
    endfunction

endpackage

// File: rtl/trk_sync.sv
module trk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/trk_pacer.sv
module trk_pacer #(
    parameter int STEP_CLKS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic freeze,
    output logic tick
);
    localparam int CNT_W = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_CLKS - 1);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt;

    assign tick = (cnt == LAST) && !freeze && !clear;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (!freeze) begin
            cnt <= tick ? '0 : cnt + ONE;
        end
    end
endmodule

// File: rtl/trk_dir.sv
module trk_dir
    import trk_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  conv_state_e       state,
    input  trk_ctl_t          ctl,
    input  logic              cmp,
    input  logic [CODE_W-1:0] code,
    output trk_dec_t          dec
);
    logic at_max;
    logic at_zero;

    assign at_max  = &code;
    assign at_zero = ~|code;

    always_comb begin
        dec.move   = MV_NONE;
        dec.finish = 1'b0;
        if (state == ST_CONV) begin
            if (cmp && !at_max) dec.move   = MV_UP;
            else                dec.finish = 1'b1;
        end else if (ctl.track) begin
            if (cmp && !ctl.up_off && !at_max)
                dec.move = MV_UP;
            else if (!cmp && !ctl.down_off && !at_zero)
                dec.move = MV_DOWN;
        end
    end
endmodule

// File: rtl/trk_conv.sv
module trk_conv
    import trk_pkg::*;
#(
    parameter int CODE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_track,
    input  logic              start,
    input  logic              hold,
    input  logic              no_up,
    input  logic              no_down,
    input  logic              cmp_above,
    output logic [CODE_W-1:0] dac_code,
    output logic [CODE_W-1:0] result,
    output logic              eoc
);
    localparam int STEP_CLKS = pace_clks(SYNC_STAGES);
    localparam logic [CODE_W-1:0] ONE = CODE_W'(1);

    conv_state_e       state;
    trk_ctl_t          ctl;
    trk_dec_t          dec;
    logic              cmp_s;
    logic              tick;
    logic              start_ok;
    logic [CODE_W-1:0] code_next;

    assign ctl.track    = mode_track;
    assign ctl.freeze   = hold;
    assign ctl.up_off   = no_up;
    assign ctl.down_off = no_down;

    assign start_ok = start && !ctl.track && !ctl.freeze && (state == ST_IDLE);

    trk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (cmp_above),
        .q   (cmp_s)
    );

    trk_pacer #(.STEP_CLKS(STEP_CLKS)) u_pacer (
        .clk    (clk),
        .rst    (rst),
        .clear  (start_ok),
        .freeze (ctl.freeze),
        .tick   (tick)
    );

    trk_dir #(.CODE_W(CODE_W)) u_dir (
        .state (state),
        .ctl   (ctl),
        .cmp   (cmp_s),
        .code  (dac_code),
        .dec   (dec)
    );

    always_comb begin
        unique case (dec.move)
            MV_UP:   code_next = dac_code + ONE;
            MV_DOWN: code_next = dac_code - ONE;
            default: code_next = dac_code;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            dac_code <= '0;
            result   <= '0;
            eoc      <= 1'b1;
        end else if (!ctl.freeze) begin
            if (start_ok) begin
                state    <= ST_CONV;
                dac_code <= '0;
                eoc      <= 1'b0;
            end else if (tick) begin
                if (state == ST_CONV) begin
                    if (dec.finish) begin
                        state  <= ST_IDLE;
                        result <= dac_code;
                        eoc    <= 1'b1;
                    end else begin
                        dac_code <= code_next;
                    end
                end else if (ctl.track) begin
                    dac_code <= code_next;
                    result   <= code_next;
                end
            end
        end
    end
endmodule

// File: rtl/trk_conv_chk.sv
module trk_conv_chk #(
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              mode_track,
    input logic              start,
    input logic              hold,
    input logic              no_up,
    input logic              no_down,
    input logic [CODE_W-1:0] dac_code,
    input logic [CODE_W-1:0] result,
    input logic              eoc
);
    localparam logic [CODE_W-1:0] ONE = CODE_W'(1);
    localparam logic [CODE_W-1:0] MAX = '1;

    logic accept;
    assign accept = start && eoc && !mode_track && !hold;

    assert_start_clears_R2: assert property (@(posedge clk) disable iff (rst)
        accept |=> (dac_code == '0) && !eoc);

    assert_count_up_R3: assert property (@(posedge clk) disable iff (rst)
        (!eoc && !hold) |=> (dac_code == $past(dac_code)) || (dac_code == $past(dac_code) + ONE));

    assert_no_wrap_top_R4: assert property (@(posedge clk) disable iff (rst)
        (dac_code == MAX && !accept) |=> (dac_code == MAX) || (dac_code == MAX - ONE));

    assert_busy_start_R5: assert property (@(posedge clk) disable iff (rst)
        (!eoc && start) |=> (dac_code >= $past(dac_code)));

    assert_single_step_R6: assert property (@(posedge clk) disable iff (rst)
        (!accept) |=> (dac_code == $past(dac_code)) || (dac_code == $past(dac_code) + ONE)
                      || (dac_code == $past(dac_code) - ONE));

    assert_hold_freeze_R7: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(dac_code) && $stable(result) && $stable(eoc));

    assert_min_capture_R8: assert property (@(posedge clk) disable iff (rst)
        (no_up && mode_track && eoc) |=> (dac_code <= $past(dac_code)));

    assert_max_capture_R9: assert property (@(posedge clk) disable iff (rst)
        (no_down && mode_track && eoc) |=> (dac_code >= $past(dac_code)));

    assert_track_no_start_R11: assert property (@(posedge clk) disable iff (rst)
        (mode_track && eoc) |=> eoc);
endmodule

bind trk_conv trk_conv_chk #(.CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode_track (mode_track),
    .start      (start),
    .hold       (hold),
    .no_up      (no_up),
    .no_down    (no_down),
    .dac_code   (dac_code),
    .result     (result),
    .eoc        (eoc)
);

// File: tb/trk_conv_tb.sv
module trk_conv_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         mode_track = 1'b0;
    logic         start = 1'b0;
    logic         hold = 1'b0;
    logic         no_up = 1'b0;
    logic         no_down = 1'b0;
    logic         force_hi = 1'b0;
    logic [W-1:0] vin = '0;
    logic         cmp_above;
    logic [W-1:0] dac_code;
    logic [W-1:0] result;
    logic         eoc;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit finished = 1'b0;

    typedef struct {
        int    val;
        int    when;
        string tag;
    } exp_t;
    exp_t sb[$];

    // External DAC plus comparator model
    assign cmp_above = force_hi ? 1'b1 : (vin > dac_code);

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    trk_conv #(.CODE_W(W), .SYNC_STAGES(2)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .mode_track (mode_track),
        .start      (start),
        .hold       (hold),
        .no_up      (no_up),
        .no_down    (no_down),
        .cmp_above  (cmp_above),
        .dac_code   (dac_code),
        .result     (result),
        .eoc        (eoc)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Monitor: pops one expected item per completed conversion
    logic prev_eoc = 1'b1;
    always @(negedge clk) begin
        if (!rst) begin
            if (eoc === 1'b1 && prev_eoc === 1'b0) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R5 unexpected completion", int'(result), -1);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(int'(result) == e.val, {e.tag, " result"}, int'(result), e.val);
                    chk(cyc == e.when, {e.tag, " completion cycle"}, cyc, e.when);
                end
            end
            prev_eoc = eoc;
        end
    end

    // Driver: one single-shot conversion
    task automatic convert(input int v, input int hold_len, input bit busy_start,
                           input string tag);
        int rec;
        exp_t e;
        @(negedge clk);
        vin   = W'(v);
        start = 1'b1;
        @(posedge clk);
        #1 rec = cyc;
        e.val  = force_hi ? 255 : v;
        e.when = rec + 3 * (e.val + 1) + hold_len;
        e.tag  = tag;
        sb.push_back(e);
        @(negedge clk);
        start = 1'b0;
        chk(dac_code == '0 && eoc == 1'b0, "R2 start clears code", int'(dac_code), 0);
        if (hold_len > 0) begin
            logic [W-1:0] held;
            repeat (10) @(negedge clk);
            held = dac_code;
            hold = 1'b1;
            repeat (hold_len) @(negedge clk);
            chk(dac_code == held && eoc == 1'b0, "R7 hold freezes conversion",
                int'(dac_code), int'(held));
            hold = 1'b0;
        end
        if (busy_start) begin
            repeat (30) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (eoc !== 1'b1) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(dac_code == '0 && result == '0 && eoc == 1'b1, "R1 reset state",
            int'(dac_code), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(dac_code == '0 && result == '0 && eoc == 1'b1, "R1 after release",
            int'(result), 0);

        // R3: several levels, timing grows with the input
        convert(0,   0, 1'b0, "R3 v=0");
        convert(1,   0, 1'b0, "R3 v=1");
        convert(77,  0, 1'b0, "R3 v=77");
        convert(200, 0, 1'b0, "R3 v=200");

        // R4: comparator stuck high saturates at all-ones
        force_hi = 1'b1;
        convert(0, 0, 1'b0, "R4 saturate");
        force_hi = 1'b0;

        // R5: start while busy ignored
        convert(50, 0, 1'b1, "R5 busy start");

        // R7: hold lengthens conversion
        convert(30, 20, 1'b0, "R7 hold in conversion");

        // R5: start on the completion edge
        begin
            int rec;
            exp_t e;
            @(negedge clk);
            vin = 8'd12;
            start = 1'b1;
            @(posedge clk);
            #1 rec = cyc;
            e.val = 12; e.when = rec + 39; e.tag = "R5 same-edge";
            sb.push_back(e);
            @(negedge clk);
            start = 1'b0;
            while (cyc != rec + 38) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(eoc == 1'b1 && dac_code == 8'd12, "R5 start on completion edge ignored",
                int'(dac_code), 12);
            settle(10);
            chk(eoc == 1'b1 && result == 8'd12, "R5 no restart after same-edge start",
                int'(result), 12);
        end

        // R6: tracking up and down
        mode_track = 1'b1;
        vin = 8'd100;
        settle(3 * 110);
        chk((dac_code == 8'd99 || dac_code == 8'd100) && result == dac_code,
            "R6 track up to 100", int'(dac_code), 100);
        vin = 8'd30;
        settle(3 * 80);
        chk((dac_code == 8'd29 || dac_code == 8'd30) && result == dac_code,
            "R6 track down to 30", int'(dac_code), 30);

        // R7: hold in tracking
        begin
            logic [W-1:0] held;
            @(negedge clk);
            hold = 1'b1;
            @(negedge clk);
            held = dac_code;
            vin = 8'd150;
            settle(60);
            chk(dac_code == held && result == held, "R7 hold in tracking",
                int'(dac_code), int'(held));
            hold = 1'b0;
        end
        settle(3 * 130);
        chk(dac_code == 8'd149 || dac_code == 8'd150, "R6 track after hold",
            int'(dac_code), 150);

        // R8: minimum capture
        no_up = 1'b1;
        vin = 8'd60;
        settle(3 * 100);
        chk(dac_code == 8'd59, "R8 minimum reached", int'(dac_code), 59);
        vin = 8'd90;
        settle(60);
        chk(dac_code == 8'd59, "R8 minimum kept on rise", int'(dac_code), 59);
        vin = 8'd40;
        settle(3 * 30);
        chk(dac_code == 8'd39, "R8 new minimum", int'(dac_code), 39);
        no_up = 1'b0;

        // R9: maximum capture
        no_down = 1'b1;
        vin = 8'd200;
        settle(3 * 170);
        chk(dac_code == 8'd200, "R9 maximum reached", int'(dac_code), 200);
        vin = 8'd150;
        settle(60);
        chk(dac_code == 8'd200, "R9 maximum kept on fall", int'(dac_code), 200);
        no_down = 1'b0;

        // R10: tracking saturation both ends
        force_hi = 1'b1;
        settle(3 * 70);
        chk(dac_code == 8'd255, "R10 saturate high", int'(dac_code), 255);
        settle(30);
        chk(dac_code == 8'd255, "R10 stays high", int'(dac_code), 255);

        // R11: start ignored in tracking
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(eoc == 1'b1 && dac_code == 8'd255, "R11 start ignored in tracking",
            int'(dac_code), 255);

        force_hi = 1'b0;
        vin = 8'd0;
        settle(3 * 265);
        chk(dac_code == 8'd0, "R10 saturate low", int'(dac_code), 0);
        settle(30);
        chk(dac_code == 8'd0, "R10 stays low", int'(dac_code), 0);

        chk(sb.size() == 0, "R3 scoreboard drained", sb.size(), 0);
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
        summary();
    end
endmodule